// File: doc/BRIEF.md
# Debounced Level Interrupt Bank

This block watches eight external input lines. Each line is brought into the clock domain through two flops. It then passes a filter that counts millisecond ticks. The filtered level can be read back through a small register bank and compared against a per-channel level select. When a channel is armed and its filtered level matches the selected polarity, the channel latches a status bit. Enabled status bits are ORed into one interrupt line.

Capture is single-shot. A capture clears the channel's arm bit, so the channel stays quiet until software writes the arm bit again, even if the level persists. Only levels are detected. Software that needs edge behaviour flips the level select after each event. The debounce timebase comes from an external one-cycle millisecond tick pulse.

Top module: `lvl_irq_bank`

## Requirements
- R1: Reading offset 0x00 returns, in bit n, channel n's debounced level when bit n of the enable register at 0x04 is 1, and 0 when that bit is 0.
- R2: Each input passes two synchroniser flops. Its debounced level takes the new value on the N-th tick during which the synchronised input has differed from it. N is the low 12 bits of the control word at 0x40 + 4*n.
- R3: An input change that reverts before N ticks have elapsed leaves the debounced level unchanged.
- R4: A control value of 0 acts as N = 1. Control word bits 31..12 read back as 0.
- R5: Level select at 0x14: bit 1 means the channel matches while its debounced level is high, and bit 0 means it matches while the level is low. While a channel is armed and matches, bit n of raw status at 0x1C is set on the next clock.
- R6: The arm register at 0x28 is read/write. A capture clears the channel's arm bit. A channel with its arm bit at 0 never sets raw status.
- R7: Writing 1 to bit n of 0x24 clears raw status bit n. Writing 0 leaves it unchanged, and 0x24 reads as 0.
- R8: Masked status at 0x20 equals raw status AND interrupt enable at 0x18. `irq_out` is 1 exactly when masked status is non-zero.
- R9: After reset every register reads 0, every debounced level is 0 and `irq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| pin_in | input | NUM_CH | Raw external input lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_out | output | 1 | Combined interrupt |

## Verification
A vector table drives several pin patterns, each against a different level-select word. The patterns include all-high, all-low, alternating and mixed nibble mixes. Together they show that polarity inversion acts per bit, that raw status follows match rather than pin value, and that the interrupt enable masks per channel, including a case where only masked-off channels fire. Directed runs cover the rest. Sampling just before and just after the N-th tick pins down the exact filter length. A short glitch shows that the counter restarts. Holding a matching level after a clear shows the single-shot behaviour, and a re-arm shows the channel fires again.

// File: rtl/lvl_bank_pkg.sv
package lvl_bank_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam logic [ADDR_W-1:0] OFS_LEVEL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_POL    = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_IEN    = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_RAW    = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_MASKED = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_CLR    = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_ARM    = 8'h28;
  localparam int                OFS_DLEN   = 'h40;
endpackage

// File: rtl/lvl_bank_sync.sv
module lvl_bank_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/lvl_bank_filter.sv
module lvl_bank_filter #(
  parameter int DB_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            din,
  input  logic [DB_W-1:0] len,
  output logic            dout
);
  logic [DB_W-1:0] cnt_q, cnt_d, lim;
  logic            dout_d;
  logic            upd_en;

  always_comb begin
    lim    = (len == '0) ? DB_W'(1) : len;
    cnt_d  = cnt_q;
    dout_d = dout;
    if (din == dout) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q + 1'b1 >= lim) begin
        dout_d = din;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  assign upd_en = (cnt_d != cnt_q) || (dout_d != dout);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dout  <= 1'b0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      dout  <= dout_d;
    end
  end

  AST_DBNC_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(dout)); // R2

  AST_DBNC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> (dout == $past(din))); // R2
endmodule

// File: rtl/lvl_bank_regs.sv
module lvl_bank_regs
  import lvl_bank_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DB_W   = 12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [NUM_CH-1:0]              deb,
  output logic [DATA_W-1:0]              rdata,
  output logic [NUM_CH-1:0][DB_W-1:0]    dlen,
  output logic                           irq
);
  logic [NUM_CH-1:0] en_q, en_d, pol_q, pol_d, ien_q, ien_d;
  logic [NUM_CH-1:0] raw_q, raw_d, arm_q, arm_d;
  logic [NUM_CH-1:0][DB_W-1:0] dlen_q, dlen_d;
  logic [NUM_CH-1:0] match, cap, clr;
  logic unused_wdata;

  assign unused_wdata = ^wdata[DATA_W-1:DB_W];

  assign match = ~(deb ^ pol_q);
  assign cap   = arm_q & match;
  assign clr   = (we && addr == OFS_CLR) ? wdata[NUM_CH-1:0] : '0;

  always_comb begin
    en_d   = en_q;
    pol_d  = pol_q;
    ien_d  = ien_q;
    arm_d  = arm_q;
    dlen_d = dlen_q;
    if (we) begin
      if (addr == OFS_ENABLE) en_d  = wdata[NUM_CH-1:0];
      if (addr == OFS_POL)    pol_d = wdata[NUM_CH-1:0];
      if (addr == OFS_IEN)    ien_d = wdata[NUM_CH-1:0];
      if (addr == OFS_ARM)    arm_d = wdata[NUM_CH-1:0];
      for (int i = 0; i < NUM_CH; i++) begin
        if (addr == ADDR_W'(OFS_DLEN + 4 * i)) dlen_d[i] = wdata[DB_W-1:0];
      end
    end
    arm_d = arm_d & ~cap;
    raw_d = (raw_q & ~clr) | cap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '0;
      ien_q  <= '0;
      arm_q  <= '0;
      raw_q  <= '0;
      dlen_q <= '0;
    end else begin
      en_q   <= en_d;
      pol_q  <= pol_d;
      ien_q  <= ien_d;
      arm_q  <= arm_d;
      raw_q  <= raw_d;
      dlen_q <= dlen_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      OFS_LEVEL:  rdata = DATA_W'(deb & en_q);
      OFS_ENABLE: rdata = DATA_W'(en_q);
      OFS_POL:    rdata = DATA_W'(pol_q);
      OFS_IEN:    rdata = DATA_W'(ien_q);
      OFS_RAW:    rdata = DATA_W'(raw_q);
      OFS_MASKED: rdata = DATA_W'(raw_q & ien_q);
      OFS_ARM:    rdata = DATA_W'(arm_q);
      default: begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (addr == ADDR_W'(OFS_DLEN + 4 * i)) rdata = DATA_W'(dlen_q[i]);
        end
      end
    endcase
  end

  assign dlen = dlen_q;
  assign irq  = |(raw_q & ien_q);

  AST_CAPTURE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_q & ~$past(raw_q) & ~$past(arm_q)) == '0)); // R6

  AST_DISARM_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_q & ~$past(raw_q) & arm_q) == '0)); // R6

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_q & $past(clr) & ~$past(arm_q & match)) == '0)); // R7
endmodule

// File: rtl/lvl_irq_bank.sv
module lvl_irq_bank #(
  parameter int NUM_CH = 8,
  parameter int DB_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic [NUM_CH-1:0] pin_in,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_out
);
  logic [NUM_CH-1:0]            pin_s;
  logic [NUM_CH-1:0]            deb;
  logic [NUM_CH-1:0][DB_W-1:0]  dlen;

  lvl_bank_sync #(.W(NUM_CH)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    lvl_bank_filter #(.DB_W(DB_W)) filt_i (
      .clk(clk), .rst_n(rst_n), .tick(ms_tick),
      .din(pin_s[g]), .len(dlen[g]), .dout(deb[g])
    );
  end

  lvl_bank_regs #(.NUM_CH(NUM_CH), .DB_W(DB_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .deb(deb), .rdata(reg_rdata),
    .dlen(dlen), .irq(irq_out)
  );

  AST_IRQ_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq_out); // R9
endmodule

// File: tb/lvl_irq_bank_tb.sv
module lvl_irq_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ms_tick;
  logic [7:0]  pin_in;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  lvl_irq_bank dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pin_in(pin_in),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  // pattern, level select, expected raw, expected masked (ien = 0x0F), expected irq
  localparam logic [32:0] VEC [6] = '{
    {8'hA5, 8'hFF, 8'hA5, 8'h05, 1'b1},
    {8'hA5, 8'h00, 8'h5A, 8'h0A, 1'b1},
    {8'h3C, 8'hF0, 8'h33, 8'h03, 1'b1},
    {8'hFF, 8'h0F, 8'h0F, 8'h0F, 1'b1},
    {8'h00, 8'h00, 8'hFF, 8'h0F, 1'b1},
    {8'hF0, 8'hFF, 8'hF0, 8'h00, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ms_tick = 1'b1;
      @(negedge clk); ms_tick = 1'b0;
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; ms_tick = 1'b0; pin_in = '0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    rd(8'h00, v); chk("R9 level", v, 0);
    rd(8'h04, v); chk("R9 enable", v, 0);
    rd(8'h1C, v); chk("R9 raw", v, 0);
    rd(8'h28, v); chk("R9 arm", v, 0);
    rd(8'h40, v); chk("R9 dlen0", v, 0);
    chk("R9 irq", {31'b0, irq_out}, 0);

    // R2 exact filter length on channel 0 (N=3)
    wr(8'h04, 32'hFF);
    wr(8'h40, 32'd3);
    pin_in[0] = 1'b1; settle();
    ticks(2);
    rd(8'h00, v); chk("R2 before Nth tick", v & 32'h1, 0);
    ticks(1);
    rd(8'h00, v); chk("R2 after Nth tick", v & 32'h1, 1);

    // R3 glitch shorter than N
    pin_in[0] = 1'b0; settle(); ticks(2);
    pin_in[0] = 1'b1; settle(); ticks(3);
    rd(8'h00, v); chk("R3 glitch ignored", v & 32'h1, 1);

    // R4 zero length acts as one, upper bits read zero
    wr(8'h44, 32'hFFFF_F000);
    rd(8'h44, v); chk("R4 zero readback", v, 0);
    wr(8'h48, 32'hFFFF_F005);
    rd(8'h48, v); chk("R4 upper bits zero", v, 32'h005);
    pin_in[1] = 1'b1; settle(); ticks(1);
    rd(8'h00, v); chk("R4 one tick", v & 32'h3, 32'h3);

    // R1 enable gates the level readout
    wr(8'h04, 32'hFE);
    rd(8'h00, v); chk("R1 enable gating", v, 32'h02);
    wr(8'h04, 32'hFF);

    // R5 / R6 capture, single shot, re-arm
    wr(8'h14, 32'h02);
    wr(8'h18, 32'h02);
    wr(8'h28, 32'h02);
    repeat (2) @(negedge clk);
    rd(8'h1C, v); chk("R5 raw set on match", v, 32'h02);
    rd(8'h28, v); chk("R6 arm self-cleared", v, 0);
    chk("R8 irq high", {31'b0, irq_out}, 1);
    wr(8'h24, 32'h02);
    repeat (5) @(negedge clk);
    rd(8'h1C, v); chk("R6 no refire while disarmed", v, 0);
    chk("R8 irq low", {31'b0, irq_out}, 0);
    wr(8'h28, 32'h02);
    repeat (2) @(negedge clk);
    rd(8'h1C, v); chk("R6 rearm fires again", v, 32'h02);

    // R7 clear affects only its bit, zeros ignored
    wr(8'h14, 32'h03);
    wr(8'h28, 32'h01);
    repeat (2) @(negedge clk);
    rd(8'h1C, v); chk("R5 second channel", v, 32'h03);
    wr(8'h24, 32'h01);
    rd(8'h1C, v); chk("R7 single bit clear", v, 32'h02);
    wr(8'h24, 32'h00);
    rd(8'h1C, v); chk("R7 zero write no effect", v, 32'h02);
    rd(8'h24, v); chk("R7 clear reads zero", v, 0);

    // R8 interrupt enable off masks everything
    wr(8'h18, 32'h00);
    rd(8'h20, v); chk("R8 masked off", v, 0);
    chk("R8 irq masked", {31'b0, irq_out}, 0);

    // vector table, all channels N=2
    for (int c = 0; c < 8; c++) wr(8'(8'h40 + 4 * c), 32'd2);
    wr(8'h18, 32'h0F);
    for (int k = 0; k < 6; k++) begin
      wr(8'h28, 32'h00);
      pin_in = VEC[k][32:25];
      settle(); ticks(2);
      wr(8'h14, {24'b0, VEC[k][24:17]});
      wr(8'h24, 32'hFF);
      wr(8'h28, 32'hFF);
      repeat (2) @(negedge clk);
      rd(8'h00, v); chk("R1 table level", v, {24'b0, VEC[k][32:25]});
      rd(8'h1C, v); chk("R5 table raw", v, {24'b0, VEC[k][16:9]});
      rd(8'h20, v); chk("R8 table masked", v, {24'b0, VEC[k][8:1]});
      chk("R8 table irq", {31'b0, irq_out}, {31'b0, VEC[k][0]});
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule